// File: doc/BRIEF.md
# Pipelined Burst SRAM with Two-Bit Beat Counter

This block is a synchronous, pipelined static memory with registered inputs and an internal burst counter. Address, control and write data are captured on the rising clock edge. On the next edge the block performs one access to its array, built from byte lanes. A new burst starts when either of two address strobes is low while the chip enable is active. Later cycles that have the advance input low step a two-bit beat counter. That counter gives the low two bits of the accessed word in linear (wrap-around) or interleaved order.

Reads are registered a second time, so the data of an address captured at edge N can be seen after edge N+1. Writes use the registered lane enables, which lets the byte decision arrive together with the address. A sleep input stops all accesses without losing the burst position. The output enable forces the data output to zero and clears its valid flag at once. Together these two outputs model a high-impedance bus.

Top module: `burst_sram`

## Requirements
- R1: While reset is held and after it is released, and until the first read finishes, `rvalid` is 0. `rdata` is 0 while `oe_n` is high.
- R2: If a read access uses inputs captured at edge N, then after edge N+1 `rvalid` is 1 and `rdata` holds the accessed word. Lane i is bits [8i+7:8i].
- R3: When `order_linear`=1, beat k of a burst reads the word whose low two address bits are (start low bits + k) mod 4. The upper address bits keep their start value.
- R4: When `order_linear`=0, beat k of a burst uses the low two bits (start low bits XOR k). The upper bits keep their start value.
- R5: During an open burst, a cycle with no strobe and `adv_n`=0 steps the beat count by one, and the count wraps from 3 to 0. With `adv_n`=1 the same beat is accessed again.
- R6: A low level on either `strobe_cpu_n` or `strobe_ctl_n` with `ce_n`=0 loads the start address and resets the beat count to 0. That same cycle accesses the start address. A strobe takes precedence over advance.
- R7: `wr_all_n`=0 during an access writes all four lanes of the accessed word from `wdata`.
- R8: When `wr_all_n`=1 and `wr_byte_n`=0, only the lanes with `lane_sel_n[i]`=0 are written and the other lanes keep their content. If no lane is selected, or `wr_byte_n`=1, the access is a read.
- R9: A write access produces `rvalid`=0 after its execution edge.
- R10: A cycle captured with `sleep`=1 performs no access and gives `rvalid`=0. It leaves the burst start address, the beat count and the open-burst state unchanged.
- R11: `oe_n`=1 forces `rdata` to 0 and `rvalid` to 0 in the same cycle, without waiting for a clock edge.
- R12: A strobe with `ce_n`=1 ends the burst. `rvalid` is 0 exactly one edge after that cycle is captured, and no further advance makes an access until a new selected strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, sampled when a strobe is low |
| ce_n | input | 1 | Active-low chip enable, qualifies strobes |
| strobe_cpu_n | input | 1 | Active-low processor address strobe |
| strobe_ctl_n | input | 1 | Active-low controller address strobe |
| adv_n | input | 1 | Active-low burst advance |
| wr_all_n | input | 1 | Active-low write of every lane |
| wr_byte_n | input | 1 | Active-low enable for per-lane writes |
| lane_sel_n | input | LANES | Active-low per-lane write selects |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| sleep | input | 1 | Power-down, blocks accesses |
| oe_n | input | 1 | Active-low output enable (combinational) |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, 0 while idle |
| rvalid | output | 1 | Read data valid, stands in for a driven bus |

## Verification
Sleep, advance and a new strobe can all land in the same captured cycle. Write selects can also coincide with an advance into the next beat. Random stimulus sets the strobes, advance, sleep, deselect and both write enables on their own, so these overlaps happen often. Directed cases then place a sleep inside a burst and a byte write on an advanced beat. A bench model built from the precedence order (sleep, then strobe, then advance) predicts each beat address and array word. Every cycle is compared against it, including the held position after a sleep.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   localparam int BEAT_W = 2;

   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } burst_order_e;

   // Low address bits of a beat from the start bits and the beat count.
   function automatic logic [BEAT_W-1:0] beat_low(
      input logic [BEAT_W-1:0] start_lo,
      input logic [BEAT_W-1:0] count,
      input burst_order_e      order
   );
      if (order == ORD_LINEAR)
         beat_low = start_lo + count;
      else
         beat_low = start_lo ^ count;
   endfunction

endpackage

// File: rtl/bs_in_reg.sv
module bs_in_reg #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   input  logic              wr_all_n,
   input  logic              wr_byte_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              order_linear,
   input  logic              sleep,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic              ce_n_q,
   output logic              strobe_q,
   output logic              adv_n_q,
   output logic              wr_all_n_q,
   output logic              wr_byte_n_q,
   output logic [LANES-1:0]  lane_sel_n_q,
   output logic              order_linear_q,
   output logic              sleep_q,
   output logic [DATA_W-1:0] wdata_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q         <= '0;
         ce_n_q         <= 1'b1;
         strobe_q       <= 1'b0;
         adv_n_q        <= 1'b1;
         wr_all_n_q     <= 1'b1;
         wr_byte_n_q    <= 1'b1;
         lane_sel_n_q   <= '1;
         order_linear_q <= 1'b0;
         sleep_q        <= 1'b0;
         wdata_q        <= '0;
      end else begin
         addr_q         <= addr;
         ce_n_q         <= ce_n;
         strobe_q       <= ~(strobe_cpu_n & strobe_ctl_n);
         adv_n_q        <= adv_n;
         wr_all_n_q     <= wr_all_n;
         wr_byte_n_q    <= wr_byte_n;
         lane_sel_n_q   <= lane_sel_n;
         order_linear_q <= order_linear;
         sleep_q        <= sleep;
         wdata_q        <= wdata;
      end
   end

endmodule

// File: rtl/bs_burst_ctl.sv
module bs_burst_ctl
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_q,
   input  logic              strobe_q,
   input  logic              ce_n_q,
   input  logic              adv_n_q,
   input  logic              order_linear_q,
   input  logic [ADDR_W-1:0] addr_q,
   output logic              acc_en,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              active_o,
   output logic [BEAT_W-1:0] cnt_o,
   output logic [ADDR_W-1:0] base_o
);

   logic              active_r, active_n;
   logic [BEAT_W-1:0] cnt_r, cnt_n;
   logic [ADDR_W-1:0] base_r, base_n;
   burst_order_e      order;

   assign order = order_linear_q ? ORD_LINEAR : ORD_INTERLEAVE;

   // Precedence: sleep, then strobe (load or deselect), then advance/hold.
   always_comb begin
      active_n = active_r;
      cnt_n    = cnt_r;
      base_n   = base_r;
      acc_en   = 1'b0;
      if (!sleep_q) begin
         if (strobe_q) begin
            if (ce_n_q) begin
               active_n = 1'b0;
            end else begin
               active_n = 1'b1;
               base_n   = addr_q;
               cnt_n    = '0;
               acc_en   = 1'b1;
            end
         end else if (active_r) begin
            if (!adv_n_q)
               cnt_n = cnt_r + 1'b1;
            acc_en = 1'b1;
         end
      end
   end

   assign acc_addr = {base_n[ADDR_W-1:BEAT_W],
                      beat_low(base_n[BEAT_W-1:0], cnt_n, order)};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_r <= 1'b0;
         cnt_r    <= '0;
         base_r   <= '0;
      end else begin
         active_r <= active_n;
         cnt_r    <= cnt_n;
         base_r   <= base_n;
      end
   end

   assign active_o = active_r;
   assign cnt_o    = cnt_r;
   assign base_o   = base_r;

endmodule

// File: rtl/bs_array.sv
module bs_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [LANES-1:0]  wmask,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_q,
   output logic              rd_valid_q
);

   logic rd_en;
   assign rd_en = acc_en && (wmask == '0);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (acc_en && wmask[g])
            lane_mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_q <= '0;
         else if (rd_en)
            lane_q <= lane_mem[acc_addr];
      end

      assign rd_q[g*LANE_W +: LANE_W] = lane_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_valid_q <= 1'b0;
      else
         rd_valid_q <= rd_en;
   end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   input  logic              wr_all_n,
   input  logic              wr_byte_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              order_linear,
   input  logic              sleep,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   if (ADDR_W < BEAT_W + 1) begin : g_bad_addr
      $error("burst_sram: ADDR_W must exceed the beat width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("burst_sram: LANES and LANE_W must be positive");
   end
   if (ADDR_W > 16) begin : g_bad_depth
      $error("burst_sram: ADDR_W too large for an inferred array");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              ce_n_q, strobe_q, adv_n_q;
   logic              wr_all_n_q, wr_byte_n_q, order_linear_q, sleep_q;
   logic [LANES-1:0]  lane_sel_n_q;
   logic [DATA_W-1:0] wdata_q;

   logic              acc_en;
   logic [ADDR_W-1:0] acc_addr;
   logic              burst_active;
   logic [BEAT_W-1:0] burst_cnt;
   logic [ADDR_W-1:0] burst_base;
   logic [LANES-1:0]  wmask;
   logic [DATA_W-1:0] rd_q;
   logic              rd_valid_q;

   bs_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
      .clk, .rst_n, .addr, .ce_n, .strobe_cpu_n, .strobe_ctl_n, .adv_n,
      .wr_all_n, .wr_byte_n, .lane_sel_n, .order_linear, .sleep, .wdata,
      .addr_q, .ce_n_q, .strobe_q, .adv_n_q, .wr_all_n_q, .wr_byte_n_q,
      .lane_sel_n_q, .order_linear_q, .sleep_q, .wdata_q
   );

   bs_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk, .rst_n, .sleep_q, .strobe_q, .ce_n_q, .adv_n_q, .order_linear_q,
      .addr_q, .acc_en, .acc_addr,
      .active_o(burst_active), .cnt_o(burst_cnt), .base_o(burst_base)
   );

   // Global write wins; otherwise the per-lane selects under the byte enable.
   always_comb begin
      if (!wr_all_n_q)
         wmask = '1;
      else if (!wr_byte_n_q)
         wmask = ~lane_sel_n_q;
      else
         wmask = '0;
   end

   bs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk, .rst_n, .acc_en, .acc_addr, .wmask, .wdata(wdata_q),
      .rd_q, .rd_valid_q
   );

   assign rdata  = oe_n ? '0 : rd_q;
   assign rvalid = rd_valid_q & ~oe_n;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              ce_n,
   input logic              strobe_cpu_n,
   input logic              strobe_ctl_n,
   input logic              adv_n,
   input logic              wr_all_n,
   input logic              sleep,
   input logic              rvalid,
   input logic              active,
   input logic [1:0]        cnt,
   input logic [ADDR_W-1:0] base
);

   logic any_strobe;
   assign any_strobe = !(strobe_cpu_n && strobe_ctl_n);

   // R12: deselect idles the output one edge after capture
   a_r12_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (any_strobe && ce_n) |-> ##2 !rvalid);

   // R10: sleep blocks the access
   a_r10_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> ##2 !rvalid);

   // R10: sleep keeps the burst position
   a_r10_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> ##2 ($stable(cnt) && $stable(base) && $stable(active)));

   // R9: a global write never yields valid read data
   a_r9_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_all_n |-> ##2 !rvalid);

   // R5: no strobe and no advance keeps the beat
   a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_strobe && adv_n) |-> ##2 ($stable(cnt) && $stable(base)));

   // R6: selected strobe restarts at beat 0 from the presented address
   a_r6_load_start: assert property (@(posedge clk) disable iff (!rst_n)
      (any_strobe && !ce_n && !sleep) |-> ##2
         (active && cnt == 2'd0 && base == $past(addr, 2)));

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n),
   .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
   .adv_n(adv_n), .wr_all_n(wr_all_n), .sleep(sleep), .rvalid(rvalid),
   .active(burst_active), .cnt(burst_cnt), .base(burst_base)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int LN = 4;
   localparam int LW = 8;
   localparam int DW = LN * LW;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr;
   logic ce_n, strobe_cpu_n, strobe_ctl_n, adv_n, wr_all_n, wr_byte_n;
   logic [LN-1:0] lane_sel_n;
   logic order_linear, sleep, oe_n;
   logic [DW-1:0] wdata, rdata;
   logic rvalid;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
      .clk, .rst_n, .addr, .ce_n, .strobe_cpu_n, .strobe_ctl_n, .adv_n,
      .wr_all_n, .wr_byte_n, .lane_sel_n, .order_linear, .sleep, .oe_n,
      .wdata, .rdata, .rvalid
   );

   typedef struct packed {
      logic [AW-1:0] addr;
      logic ce_n, scpu_n, sctl_n, adv_n, wall_n, wbyte_n;
      logic [LN-1:0] sel_n;
      logic lin, slp;
      logic [DW-1:0] wd;
   } vec_t;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   string cur_req = "R1";

   logic [DW-1:0] ref_mem [DEPTH];
   bit m_active = 0;
   logic [AW-1:0] m_base = '0;
   logic [1:0] m_cnt = '0;
   bit exp_rv = 0;
   logic [DW-1:0] exp_rd = '0;
   vec_t prev;

   function automatic vec_t idle_v();
      vec_t v;
      v = '0;
      v.ce_n = 1; v.scpu_n = 1; v.sctl_n = 1; v.adv_n = 1;
      v.wall_n = 1; v.wbyte_n = 1; v.sel_n = '1;
      return v;
   endfunction

   function automatic vec_t ld(input logic [AW-1:0] a, input bit ctl, input bit lin);
      vec_t v = idle_v();
      v.addr = a; v.ce_n = 0; v.lin = lin;
      if (ctl) v.sctl_n = 0; else v.scpu_n = 0;
      return v;
   endfunction

   function automatic vec_t step(input bit adv, input bit lin);
      vec_t v = idle_v();
      v.ce_n = 0; v.adv_n = !adv; v.lin = lin;
      return v;
   endfunction

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {a, ~a, a ^ 8'h5a, a + 8'h33};
   endfunction

   function automatic logic [AW-1:0] beat_a(input logic [AW-1:0] b,
                                            input logic [1:0] c, input bit lin);
      logic [1:0] lo;
      lo = lin ? (b[1:0] + c) : (b[1:0] ^ c);
      return {b[AW-1:2], lo};
   endfunction

   task automatic access(input vec_t q, input logic [AW-1:0] a);
      logic [LN-1:0] m;
      if (!q.wall_n) m = '1;
      else if (!q.wbyte_n) m = ~q.sel_n;
      else m = '0;
      if (m != 0) begin
         for (int i = 0; i < LN; i++)
            if (m[i]) ref_mem[a][i*LW +: LW] = q.wd[i*LW +: LW];
         exp_rv = 0;
      end else begin
         exp_rd = ref_mem[a];
         exp_rv = 1;
      end
   endtask

   task automatic model(input vec_t q);
      if (q.slp) exp_rv = 0;
      else if (!q.scpu_n || !q.sctl_n) begin
         if (q.ce_n) begin m_active = 0; exp_rv = 0; end
         else begin
            m_base = q.addr; m_cnt = 0; m_active = 1;
            access(q, q.addr);
         end
      end else if (m_active) begin
         if (!q.adv_n) m_cnt = m_cnt + 1;
         access(q, beat_a(m_base, m_cnt, q.lin));
      end else exp_rv = 0;
   endtask

   task automatic check_out();
      bit e_v;
      logic [DW-1:0] e_d;
      bit bad;
      e_v = exp_rv && !oe_n;
      bad = (rvalid !== e_v);
      if (oe_n) begin e_d = '0; bad = bad || (rdata !== '0); end
      else begin e_d = exp_rd; if (exp_rv) bad = bad || (rdata !== exp_rd); end
      n_chk++;
      if (bad) begin
         n_fail++;
         $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                  cur_req, rvalid, rdata, e_v, e_d);
      end
   endtask

   task automatic drive(input vec_t v, input logic oe);
      addr = v.addr; ce_n = v.ce_n; strobe_cpu_n = v.scpu_n;
      strobe_ctl_n = v.sctl_n; adv_n = v.adv_n; wr_all_n = v.wall_n;
      wr_byte_n = v.wbyte_n; lane_sel_n = v.sel_n; order_linear = v.lin;
      sleep = v.slp; wdata = v.wd; oe_n = oe;
   endtask

   task automatic cyc(input vec_t v, input logic oe = 1'b0);
      @(negedge clk);
      check_out();
      drive(v, oe);
      model(prev);
      prev = v;
   endtask

   initial begin
      vec_t v;
      prev = idle_v();
      drive(idle_v(), 1'b0);
      repeat (3) @(negedge clk);
      // R1: reset state
      n_chk++;
      if (rvalid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: rvalid=%0b expected 0", rvalid);
      end
      rst_n = 1'b1;
      cur_req = "R1";
      cyc(idle_v(), 1'b1);
      cyc(idle_v());

      // R7: fill the array with full-word writes
      cur_req = "R7";
      for (int a = 0; a < DEPTH; a++) begin
         v = ld(a[AW-1:0], a[0], 1); v.wall_n = 0; v.wd = pat(a[AW-1:0]);
         cyc(v);
      end
      cyc(idle_v()); cyc(idle_v());

      // R2/R3: linear burst from low bits 2, including wrap past beat 3
      cur_req = "R3";
      cyc(ld(8'h12, 0, 1));
      repeat (4) cyc(step(1, 1));
      cyc(idle_v()); cyc(idle_v());

      // R4: interleaved burst from low bits 2 and 1
      cur_req = "R4";
      cyc(ld(8'h12, 0, 0));
      repeat (3) cyc(step(1, 0));
      cyc(ld(8'h45, 0, 0));
      repeat (3) cyc(step(1, 0));

      // R5: hold then advance
      cur_req = "R5";
      cyc(ld(8'h31, 0, 1));
      cyc(step(0, 1)); cyc(step(0, 1)); cyc(step(1, 1)); cyc(step(0, 1));

      // R6: controller strobe restarts mid-burst
      cur_req = "R6";
      cyc(ld(8'h20, 0, 1)); cyc(step(1, 1));
      cyc(ld(8'h83, 1, 1)); cyc(step(1, 1)); cyc(step(1, 1));

      // R8: lanes 0 and 2 written on an advanced beat, then read back
      cur_req = "R8";
      cyc(ld(8'h50, 0, 1));
      v = step(1, 1); v.wbyte_n = 0; v.sel_n = 4'b1010; v.wd = 32'hAABBCCDD;
      cyc(v);
      v = step(0, 1); v.wbyte_n = 0; v.sel_n = 4'b1111; // no lane: read
      cyc(v);
      cyc(ld(8'h51, 0, 1)); cyc(idle_v()); cyc(idle_v());

      // R9: write output idle
      cur_req = "R9";
      v = ld(8'h60, 0, 1); v.wall_n = 0; v.wd = 32'h0BADF00D;
      cyc(v); cyc(ld(8'h60, 0, 1)); cyc(idle_v());

      // R10: sleep inside a burst keeps the position
      cur_req = "R10";
      cyc(ld(8'h70, 0, 1)); cyc(step(1, 1));
      v = step(1, 1); v.slp = 1; cyc(v); cyc(v);
      cyc(step(1, 1)); cyc(step(1, 1));

      // R11: output enable high blanks the output
      cur_req = "R11";
      cyc(ld(8'h90, 0, 1)); cyc(step(1, 1), 1'b1); cyc(step(1, 1), 1'b1);
      cyc(step(1, 1));

      // R12: deselect then advances do nothing
      cur_req = "R12";
      cyc(ld(8'hA0, 0, 1)); cyc(step(1, 1));
      v = ld(8'hB0, 0, 1); v.ce_n = 1; cyc(v);
      cyc(step(1, 1)); cyc(step(1, 1)); cyc(idle_v());

      // R2: constrained random mix
      cur_req = "R2";
      void'($urandom(32'h5EED1234));
      for (int n = 0; n < 4000; n++) begin
         v = idle_v();
         v.addr = $urandom_range(0, DEPTH-1);
         v.ce_n = ($urandom_range(0, 9) == 0);
         v.scpu_n = ($urandom_range(0, 4) != 0);
         v.sctl_n = ($urandom_range(0, 9) != 0);
         v.adv_n = ($urandom_range(0, 4) < 2);
         v.wall_n = ($urandom_range(0, 9) != 0);
         v.wbyte_n = ($urandom_range(0, 6) != 0);
         v.sel_n = $urandom_range(0, 15);
         v.lin = $urandom_range(0, 1);
         v.slp = ($urandom_range(0, 19) == 0);
         v.wd = $urandom;
         cyc(v, $urandom_range(0, 9) == 0);
      end
      cyc(idle_v()); cyc(idle_v()); cyc(idle_v());

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run incomplete, expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule